// File: doc/BRIEF.md
# Serial ADC Readout Sequencer

This block is a synchronous master that fetches 12-bit results from one or more three-wire serial converters. The wires are an active-low select per device, a shared serial clock and a shared data line. The serial clock comes from the system clock: each high phase and each low phase lasts `DIV` system clocks. When a device is selected, the sequencer waits a programmable wake-up interval. It then runs two clock pulses that carry no data. After that it collects twelve bits, most significant first. Each bit is sampled in the last system clock of a low phase, just before the clock would rise.

After the twelfth sample the select goes high again with no further clock pulse. A one-cycle done strobe then marks the result, which is presented as a high byte plus a low byte whose upper nibble carries the four least significant bits. A host launches one read with a start pulse and a device index. When the continuous input is held high, the same device is read again immediately after each result, with no host action.

Top module: `adc_rdout_seq`

## Requirements
- R1: Out of reset and while idle, `sclk_o` is 0, every bit of `cs_n_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: A `start_i` pulse with `dev_sel_i` below `NUM_DEV` drives exactly bit `dev_sel_i` of `cs_n_o` low on the next cycle, and it stays low until the read ends. `busy_o` is 1 while that select is low. A start with an index of `NUM_DEV` or more is ignored, and so is a start while `busy_o` is 1.
- R3: The first rising edge of `sclk_o` comes `WAKE_CYC + DIV` system clocks after the select falls (only `DIV` when `WAKE_CYC` is 0).
- R4: Every high phase of `sclk_o` lasts `DIV` cycles, and a complete read has exactly 13 rising edges: 2 lead-in pulses and 11 after data samples.
- R5: `sdo_i` is sampled in the last cycle of each low phase from the third low phase on. The two lead-in pulses capture nothing. The twelve samples form the result, most significant bit first.
- R6: After the twelfth sample the select returns high while `sclk_o` stays low, with no rising edge after that sample.
- R7: `byte_hi_o` holds result bits 11..4 (bit 7 = result bit 11). `byte_lo_o[7:4]` holds result bits 3..0 and `byte_lo_o[3:0]` is 0. Both hold their value until the next result.
- R8: `done_o` is high for exactly one cycle per completed read: the first cycle in which all selects are high again.
- R9: If `cont_i` is 1 in the `done_o` cycle, the same device's select goes low again on the next cycle without a start. If it is 0, the sequencer returns to idle.
- R10: Synchronous active-high `rst` aborts any read. On the following cycle all selects are high, `sclk_o` is low and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch one read (sampled while idle) |
| dev_sel_i | input | DEV_W | Index of the converter to read |
| cont_i | input | 1 | Repeat reads of the same device back to back |
| sdo_i | input | 1 | Shared serial data from the converters |
| sclk_o | output | 1 | Shared serial clock |
| cs_n_o | output | NUM_DEV | Active-low select, one per device |
| busy_o | output | 1 | High while a select is low |
| done_o | output | 1 | One-cycle strobe, result bytes valid |
| byte_hi_o | output | 8 | Result bits 11..4 |
| byte_lo_o | output | 8 | Result bits 3..0 in the upper nibble, lower nibble zero |

## Verification
The assertions assume that `rst` is applied before any read and that `cont_i` only matters in the cycle where `done_o` is high. They also assume that the converter drives `sdo_i` while its select is low. The bench behaves as a converter that changes its data only after it sees a falling serial clock edge. That edge comes at least `DIV` system clocks before the sample, so every captured bit is stable. The bench drives the lead-in bits to 1 so that any capture during the lead-in would corrupt the result. Starts are driven on the falling system clock edge and last one cycle. The cases covered are out-of-range indices, a start while busy, a reset during a read and a continuous run that is stopped only after its last expected read has begun.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_BITS    = 12;
    localparam int LEAD_PULSES = 2;
    localparam int LOW_PHASES  = RES_BITS + LEAD_PULSES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_LOW,
        ST_HIGH,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expire_o = (cnt_q == term_i);

    always_ff @(posedge clk) begin
        if (rst || restart_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
        end else if (en_i) begin
            word_o <= {word_o[W-2:0], bit_i};
        end
    end
endmodule

// File: rtl/adc_cs_decode.sv
module adc_cs_decode #(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic [DEV_W-1:0]   sel_i,
    input  logic               active_i,
    output logic [NUM_DEV-1:0] cs_n_o
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign cs_n_o[i] = !(active_i && (sel_i == DEV_W'(i)));
    end
endmodule

// File: rtl/adc_rdout_seq.sv
module adc_rdout_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int DIV      = 4,
    parameter int WAKE_CYC = 4,
    localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [DEV_W-1:0]   dev_sel_i,
    input  logic               cont_i,
    input  logic               sdo_i,
    output logic               sclk_o,
    output logic [NUM_DEV-1:0] cs_n_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [7:0]         byte_hi_o,
    output logic [7:0]         byte_lo_o
);
    localparam int MAX_PH  = (DIV > WAKE_CYC) ? DIV : ((WAKE_CYC > 0) ? WAKE_CYC : 1);
    localparam int CNT_W   = $clog2(MAX_PH + 1);
    localparam int PULSE_W = $clog2(LOW_PHASES + 1);
    localparam logic [CNT_W-1:0]   DIV_TERM  = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0]   WAKE_TERM = CNT_W'((WAKE_CYC > 0) ? WAKE_CYC - 1 : 0);
    localparam logic [PULSE_W-1:0] LAST_LOW  = PULSE_W'(LOW_PHASES - 1);
    localparam logic [PULSE_W-1:0] FIRST_BIT = PULSE_W'(LEAD_PULSES);
    localparam seq_state_e         ENTRY_ST  = (WAKE_CYC == 0) ? ST_LOW : ST_WAKE;

    typedef struct packed {
        seq_state_e         st;
        logic [PULSE_W-1:0] pulse;
        logic [DEV_W-1:0]   dev;
        logic [7:0]         hi;
        logic [7:0]         lo;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic                  expire;
    logic                  sample;
    logic                  restart;
    logic [CNT_W-1:0]      term;
    logic [RES_BITS-2:0]   shift_word;
    logic [RES_BITS-1:0]   full_word;
    logic                  active;

    assign restart   = (r_q.st == ST_IDLE) || (r_q.st == ST_FIN);
    assign term      = (r_q.st == ST_WAKE) ? WAKE_TERM : DIV_TERM;
    assign full_word = {shift_word, sdo_i};

    adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .term_i    (term),
        .expire_o  (expire)
    );

    adc_shift_in #(.W(RES_BITS - 1)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en_i   (sample),
        .bit_i  (sdo_i),
        .word_o (shift_word)
    );

    always_comb begin
        r_d    = r_q;
        sample = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.pulse = '0;
                if (start_i && (int'(dev_sel_i) < NUM_DEV)) begin
                    r_d.dev = dev_sel_i;
                    r_d.st  = ENTRY_ST;
                end
            end
            ST_WAKE: begin
                if (expire) r_d.st = ST_LOW;
            end
            ST_LOW: begin
                if (expire) begin
                    sample = (r_q.pulse >= FIRST_BIT);
                    if (r_q.pulse == LAST_LOW) begin
                        r_d.st = ST_FIN;
                        r_d.hi = full_word[RES_BITS-1:RES_BITS-8];
                        r_d.lo = {full_word[RES_BITS-9:0], 4'b0000};
                    end else begin
                        r_d.st = ST_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    r_d.st    = ST_LOW;
                    r_d.pulse = r_q.pulse + PULSE_W'(1);
                end
            end
            ST_FIN: begin
                r_d.pulse = '0;
                r_d.st    = cont_i ? ENTRY_ST : ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, pulse: '0, dev: '0, hi: '0, lo: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign active = (r_q.st == ST_WAKE) || (r_q.st == ST_LOW) || (r_q.st == ST_HIGH);

    adc_cs_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_cs (
        .sel_i    (r_q.dev),
        .active_i (active),
        .cs_n_o   (cs_n_o)
    );

    assign sclk_o    = (r_q.st == ST_HIGH);
    assign busy_o    = active;
    assign done_o    = (r_q.st == ST_FIN);
    assign byte_hi_o = r_q.hi;
    assign byte_lo_o = r_q.lo;
endmodule

// File: rtl/adc_rdout_chk.sv
module adc_rdout_chk #(
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cont_i,
    input logic               sclk_o,
    input logic [NUM_DEV-1:0] cs_n_o,
    input logic               busy_o,
    input logic               done_o
);
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) rst_seen_q <= rst;

    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_idle_R10: assert (&cs_n_o && !sclk_o && !busy_o && !done_o)
                else $error("reset did not return to idle");
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (&cs_n_o) |-> !sclk_o);

    assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n_o) <= 1);

    assert_busy_select_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o == !(&cs_n_o));

    assert_select_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(cs_n_o));

    assert_clock_in_read_R4: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> busy_o);

    assert_release_low_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (&cs_n_o && !sclk_o && !$past(sclk_o)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_repeat_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && cont_i) |=> busy_o);

    assert_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cont_i) |=> !busy_o);
endmodule

bind adc_rdout_seq adc_rdout_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cont_i (cont_i),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .busy_o (busy_o),
    .done_o (done_o)
);

// File: tb/sim_adc_rdout_seq.sv
`timescale 1ns/1ps
module sim_adc_rdout_seq;
    localparam int NUM_DEV  = 3;
    localparam int DIV      = 3;
    localparam int WAKE_CYC = 4;
    localparam int DEV_W    = 2;
    localparam int LIMIT    = 150000;

    typedef struct {
        int          dev;
        logic [11:0] word;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [DEV_W-1:0]   dev_sel = '0;
    logic               cont = 1'b0;
    logic               sdo = 1'b0;
    logic               sclk;
    logic [NUM_DEV-1:0] cs_n;
    logic               busy;
    logic               done;
    logic [7:0]         b_hi;
    logic [7:0]         b_lo;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   done_cnt = 0;
    exp_t sb_q[$];
    logic [11:0] dev_word [NUM_DEV];

    always #4 clk = ~clk;

    adc_rdout_seq #(.NUM_DEV(NUM_DEV), .DIV(DIV), .WAKE_CYC(WAKE_CYC)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .dev_sel_i(dev_sel), .cont_i(cont),
        .sdo_i(sdo), .sclk_o(sclk), .cs_n_o(cs_n), .busy_o(busy), .done_o(done),
        .byte_hi_o(b_hi), .byte_lo_o(b_lo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // converter model + scoreboard monitor
    logic [NUM_DEV-1:0] prev_cs = '1;
    logic prev_sclk = 1'b0;
    int   fcnt = 0, rises = 0, hi_len = 0, t_fall = 0, conv_dev = -1;
    bit   chk_restart = 0, chk_single = 0;
    int   restart_dev = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            fcnt = 0; rises = 0; hi_len = 0; conv_dev = -1;
            chk_restart = 0; chk_single = 0;
            prev_cs = '1; prev_sclk = 1'b0; sdo = 1'b0;
        end else begin
            int d;
            d = -1;
            for (int i = 0; i < NUM_DEV; i++) if (!cs_n[i]) d = i;
            if (&cs_n) fcnt = 0;
            else if (prev_sclk && !sclk) fcnt++;
            if (d < 0) sdo = 1'b0;
            else if (fcnt < 2) sdo = 1'b1;
            else if (fcnt <= 13) sdo = dev_word[d][11 - (fcnt - 2)];
            else sdo = 1'b0;

            if (chk_single) begin
                chk(!done, "R8 done width", int'(done), 0);
                chk_single = 0;
            end
            if (chk_restart) begin
                chk(!cs_n[restart_dev] && busy, "R9 continuous restart", int'(cs_n[restart_dev]), 0);
                chk_restart = 0;
            end
            if (&prev_cs && !(&cs_n)) begin
                t_fall = cyc; rises = 0; conv_dev = d;
            end
            if (sclk && !prev_sclk) begin
                rises++;
                hi_len = 0;
                if (rises == 1) chk(cyc - t_fall == WAKE_CYC + DIV, "R3 wake delay", cyc - t_fall, WAKE_CYC + DIV);
            end
            if (sclk) hi_len++;
            if (!sclk && prev_sclk) chk(hi_len == DIV, "R4 high phase", hi_len, DIV);
            if (done) begin
                done_cnt++;
                chk_single = 1;
                if (sb_q.size() == 0) begin
                    chk(0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(b_hi == e.word[11:4], "R5 R7 high byte", int'(b_hi), int'(e.word[11:4]));
                    chk(b_lo == {e.word[3:0], 4'b0000}, "R7 low byte", int'(b_lo), int'({e.word[3:0], 4'b0000}));
                    chk(conv_dev == e.dev, "R2 device", conv_dev, e.dev);
                    chk(rises == 13, "R4 pulse count", rises, 13);
                    chk(&cs_n && !sclk, "R6 release", int'(cs_n), (1 << NUM_DEV) - 1);
                end
                if (cont) begin
                    chk_restart = 1;
                    restart_dev = conv_dev;
                end
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic pulse_start(input int d);
        @(negedge clk);
        start = 1'b1;
        dev_sel = DEV_W'(d);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic launch(input int d, input logic [11:0] w);
        exp_t e;
        dev_word[d] = w;
        e.dev = d; e.word = w;
        sb_q.push_back(e);
        pulse_start(d);
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target && cyc < LIMIT) @(negedge clk);
    endtask

    task automatic finish_run();
        chk(sb_q.size() == 0, "R8 all results seen", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NUM_DEV; i++) dev_word[i] = '0;
        repeat (3) @(negedge clk);
        chk(!sclk && &cs_n && !busy && !done, "R10 in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sclk && &cs_n && !busy && !done, "R1 idle", int'(cs_n), (1 << NUM_DEV) - 1);

        // single reads, varied patterns (R5 R7)
        launch(0, 12'hA5C); wait_done(1);
        launch(1, 12'hFFF); wait_done(2);
        launch(2, 12'h000); wait_done(3);
        launch(0, 12'h801); wait_done(4);
        launch(2, 12'h3C7); wait_done(5);

        // out-of-range index ignored (R2)
        pulse_start(3);
        repeat (20) @(negedge clk);
        chk(!busy && &cs_n, "R2 out-of-range ignored", int'(busy), 0);

        // start while busy ignored (R2)
        launch(1, 12'h5A3);
        repeat (15) @(negedge clk);
        pulse_start(2);
        wait_done(6);
        repeat (20) @(negedge clk);
        chk(!busy && &cs_n, "R2 busy start ignored", int'(busy), 0);

        // continuous mode (R9)
        begin
            exp_t e;
            dev_word[2] = 12'h6E1;
            e.dev = 2; e.word = 12'h6E1;
            for (int k = 0; k < 3; k++) sb_q.push_back(e);
            cont = 1'b1;
            pulse_start(2);
            wait_done(8);
            cont = 1'b0;
            wait_done(9);
            repeat (20) @(negedge clk);
            chk(!busy && &cs_n, "R9 stop after cont low", int'(busy), 0);
        end

        // reset during a read (R10)
        dev_word[0] = 12'h123;
        pulse_start(0);
        repeat (30) @(negedge clk);
        chk(busy, "R2 read in progress", int'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && &cs_n && !sclk, "R10 abort", int'(cs_n), (1 << NUM_DEV) - 1);
        rst = 1'b0;
        @(negedge clk);
        launch(1, 12'h9B4); wait_done(10);
        repeat (10) @(negedge clk);
        chk(b_hi == 8'h9B && b_lo == 8'h40, "R7 bytes held", int'(b_hi), 8'h9B);
        finish_run();
    end

    initial begin
        while (cyc < LIMIT) @(negedge clk);
        chk(0, "watchdog", cyc, LIMIT);
        finish_run();
    end
endmodule